// File: doc/BRIEF.md
# Priority-Threshold Interrupt Controller

This block gathers a small vector of interrupt request lines into a set of pending flags. It qualifies them with a per-source enable mask and with a programmable threshold, and drives one level-sensitive interrupt line towards a processor. Source 0 has the highest priority, and priority falls as the index rises. The threshold masks every source whose index is equal to or greater than its value. An interrupt handler can therefore raise the barrier while it services a source, and lower it again afterwards. This allows handlers to nest without touching the enable mask.

Software reaches the block over a plain 32-bit register bus with separate read and write strobes. It can read the raw pending flags and the pending-and-enabled flags. It can read and write the enable mask and the threshold. It clears flags by writing ones to an acknowledge register, and it reads a vector register that names the most urgent source currently allowed through. The bus address is a byte offset. Its two lowest bits are ignored.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable mask and all pending flags are 0, the threshold reads back as 0xF (all ones of its 4 stored bits), and irq_o is low.
- R2: A 0-to-1 change seen on src_i[i] at a clock edge sets pending flag i at that edge. A source that stays high does not set its flag again. Offset 0x00 reads the pending flags in bits [7:0].
- R3: A write to offset 0x0C clears the pending flags whose data bits are 1 and leaves the other flags unchanged.
- R4: If a rising edge on a source and an acknowledge of that same source fall in the same cycle, the flag stays set.
- R5: Offset 0x08 is the read-write enable mask, one bit per source. Offset 0x04 reads pending AND enabled.
- R6: irq_o is high exactly when at least one source is pending, enabled and admitted by the threshold. It follows the registered state with no added cycle of delay.
- R7: A threshold value of 0 keeps irq_o low whatever is pending and enabled.
- R8: A threshold value N admits only the sources with index strictly below N. Offset 0x24 reads and writes the threshold, and only data bits [3:0] are stored.
- R9: Offset 0x18 reads the lowest index that is pending, enabled and admitted. It reads 0xFFFFFFFF when no source qualifies.
- R10: Reads of unmapped offsets return 0. Writes to unmapped or read-only offsets change no state.
- R11: Read data appears on bus_rdata in the cycle after the cycle in which bus_rd is high, and it is 0 in any cycle that follows a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 8 | Interrupt source lines, synchronous to clk |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level-sensitive interrupt request |

## Verification
The bench builds the block with its default parameters: eight sources, a 32-bit data bus, 8-bit byte offsets and, derived from these, a 4-bit threshold. With eight sources, every threshold value from 0 to 8 can be walked, including the boundary where a source index equals the threshold. The 4-bit threshold also leaves values 9 to 15 that admit every source, so the truncation of a wide write and the all-ones reset value can both be observed. Pending patterns that straddle the threshold let the vector readout show the lowest admitted index moving as the barrier is raised and lowered.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    // Word offsets (byte offset >> 2) of the register map
    localparam int unsigned WOFS_STATUS = 'h00 >> 2;
    localparam int unsigned WOFS_ACTIVE = 'h04 >> 2;
    localparam int unsigned WOFS_ENABLE = 'h08 >> 2;
    localparam int unsigned WOFS_ACK    = 'h0C >> 2;
    localparam int unsigned WOFS_VECTOR = 'h18 >> 2;
    localparam int unsigned WOFS_LEVEL  = 'h24 >> 2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_ACTIVE,
        SEL_ENABLE,
        SEL_ACK,
        SEL_VECTOR,
        SEL_LEVEL
    } reg_sel_e;

    function automatic reg_sel_e decode_word(input int unsigned word);
        case (word)
            WOFS_STATUS: decode_word = SEL_STATUS;
            WOFS_ACTIVE: decode_word = SEL_ACTIVE;
            WOFS_ENABLE: decode_word = SEL_ENABLE;
            WOFS_ACK:    decode_word = SEL_ACK;
            WOFS_VECTOR: decode_word = SEL_VECTOR;
            WOFS_LEVEL:  decode_word = SEL_LEVEL;
            default:     decode_word = SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_pending.sv
// Edge capture and pending flags with write-one-to-clear acknowledge.
module irq_pending #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] ack_i,
    output logic [NUM_SRC-1:0] rise_o,
    output logic [NUM_SRC-1:0] pend_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] src_prev;
        logic [NUM_SRC-1:0] pend;
    } pend_state_t;

    pend_state_t st_d, st_q;
    logic [NUM_SRC-1:0] rise;

    always_comb begin
        rise         = src_i & ~st_q.src_prev;
        st_d         = st_q;
        st_d.src_prev = src_i;
        // new edge takes precedence over a simultaneous acknowledge
        st_d.pend    = (st_q.pend & ~ack_i) | rise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = rise;
    assign pend_o = st_q.pend;

endmodule

// File: rtl/irq_arbiter.sv
// Enable and threshold masking, request output and priority vector.
module irq_arbiter #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned LVL_W   = 4,
    parameter int unsigned DATA_W  = 32
) (
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [LVL_W-1:0]   lvl_i,
    output logic [NUM_SRC-1:0] active_o,
    output logic               irq_o,
    output logic [DATA_W-1:0]  vector_o
);

    logic [NUM_SRC-1:0] admit;
    logic [NUM_SRC-1:0] qualified;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_admit
        assign admit[g] = (32'(lvl_i) > 32'(g));
    end

    assign active_o  = pend_i & en_i;
    assign qualified = active_o & admit;
    assign irq_o     = |qualified;

    // lowest index wins: scan downwards so the last hit is the smallest
    always_comb begin
        vector_o = '1;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (qualified[i]) begin
                vector_o = DATA_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_regs.sv
// Register decode, enable and threshold storage, registered read data.
module irq_regs
    import prio_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned LVL_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_rd,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] active_i,
    input  logic [DATA_W-1:0]  vector_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic [LVL_W-1:0]   lvl_o,
    output logic [NUM_SRC-1:0] ack_o,
    output logic [DATA_W-1:0]  rdata_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [LVL_W-1:0]   lvl;
        logic [DATA_W-1:0]  rdata;
    } regs_state_t;

    regs_state_t st_d, st_q;
    reg_sel_e    sel;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        sel = decode_word(32'(bus_addr[ADDR_W-1:2]));

        case (sel)
            SEL_STATUS: rd_mux = DATA_W'(pend_i);
            SEL_ACTIVE: rd_mux = DATA_W'(active_i);
            SEL_ENABLE: rd_mux = DATA_W'(st_q.en);
            SEL_VECTOR: rd_mux = vector_i;
            SEL_LEVEL:  rd_mux = DATA_W'(st_q.lvl);
            default:    rd_mux = '0;
        endcase

        st_d       = st_q;
        st_d.rdata = bus_rd ? rd_mux : '0;
        if (bus_wr && sel == SEL_ENABLE) begin
            st_d.en = bus_wdata[NUM_SRC-1:0];
        end
        if (bus_wr && sel == SEL_LEVEL) begin
            st_d.lvl = bus_wdata[LVL_W-1:0];
        end

        ack_o = (bus_wr && sel == SEL_ACK) ? bus_wdata[NUM_SRC-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.en    <= '0;
            st_q.lvl   <= '1;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o    = st_q.en;
    assign lvl_o   = st_q.lvl;
    assign rdata_o = st_q.rdata;

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_rd,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o
);

    localparam int unsigned LVL_W = $clog2(NUM_SRC) + 1;

    logic [NUM_SRC-1:0] rise_w;
    logic [NUM_SRC-1:0] pend_w;
    logic [NUM_SRC-1:0] ack_w;
    logic [NUM_SRC-1:0] en_w;
    logic [NUM_SRC-1:0] active_w;
    logic [LVL_W-1:0]   lvl_w;
    logic [DATA_W-1:0]  vector_w;

    irq_pending #(
        .NUM_SRC (NUM_SRC)
    ) u_pending (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .ack_i  (ack_w),
        .rise_o (rise_w),
        .pend_o (pend_w)
    );

    irq_arbiter #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W),
        .DATA_W  (DATA_W)
    ) u_arbiter (
        .pend_i   (pend_w),
        .en_i     (en_w),
        .lvl_i    (lvl_w),
        .active_o (active_w),
        .irq_o    (irq_o),
        .vector_o (vector_w)
    );

    irq_regs #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .LVL_W   (LVL_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .pend_i    (pend_w),
        .active_i  (active_w),
        .vector_i  (vector_w),
        .en_o      (en_w),
        .lvl_o     (lvl_w),
        .ack_o     (ack_w),
        .rdata_o   (bus_rdata)
    );

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
    import prio_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned LVL_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] rise,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] ack,
    input logic [NUM_SRC-1:0] en,
    input logic [LVL_W-1:0]   lvl,
    input logic [DATA_W-1:0]  vector
);

    logic wr_unmapped;
    assign wr_unmapped = bus_wr &&
        (decode_word(32'(bus_addr[ADDR_W-1:2])) inside {SEL_NONE, SEL_STATUS, SEL_ACTIVE, SEL_VECTOR});

    p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((pend & $past(rise)) == $past(rise)));

    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack != '0) |=> ((pend & $past(ack & ~rise)) == '0));

    p_irq_needs_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((pend & en) != '0));

    p_level_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == '0) |-> !irq_o);

    p_vec_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vector < DATA_W'(NUM_SRC)));

    p_vec_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (vector == '1));

    p_unmapped_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_unmapped |=> ($stable(en) && $stable(lvl)));

    p_rdata_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .LVL_W   (LVL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .rise      (rise_w),
    .pend      (pend_w),
    .ack       (ack_w),
    .en        (en_w),
    .lvl       (lvl_w),
    .vector    (vector_w)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;

    localparam int unsigned NUM_SRC = 8;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned DATA_W  = 32;

    localparam logic [7:0] A_STATUS = 8'h00;
    localparam logic [7:0] A_ACTIVE = 8'h04;
    localparam logic [7:0] A_ENABLE = 8'h08;
    localparam logic [7:0] A_ACK    = 8'h0C;
    localparam logic [7:0] A_VECTOR = 8'h18;
    localparam logic [7:0] A_LEVEL  = 8'h24;
    localparam logic [31:0] NONE    = 32'hFFFF_FFFF;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] src_i = '0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic               bus_wr = 1'b0;
    logic [DATA_W-1:0]  bus_wdata = '0;
    logic               bus_rd = 1'b0;
    logic [DATA_W-1:0]  bus_rdata;
    logic               irq_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    prio_irq_ctrl #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_addr  = addr;
        bus_wdata = data;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] addr, output logic [31:0] data);
        @(negedge clk);
        bus_addr = addr;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        data     = bus_rdata;
    endtask

    task automatic read_check(input string req, input logic [7:0] addr,
                              input logic [31:0] exp);
        logic [31:0] v;
        bus_read(addr, v);
        check(req, $sformatf("read 0x%02h", addr), v, exp);
    endtask

    task automatic drive_src(input logic [NUM_SRC-1:0] v);
        @(negedge clk);
        src_i = v;
    endtask

    task automatic pulse_src(input logic [NUM_SRC-1:0] v);
        drive_src(v);
        drive_src('0);
    endtask

    task automatic t_reset;
        read_check("R1", A_ENABLE, 32'h0);
        read_check("R1", A_STATUS, 32'h0);
        read_check("R1", A_LEVEL, 32'h0000_000F);
        check("R1", "irq after reset", 32'(irq_o), 32'h0);
        read_check("R9", A_VECTOR, NONE);
    endtask

    task automatic t_edge;
        drive_src(8'h05);
        @(negedge clk);
        read_check("R2", A_STATUS, 32'h05);
        bus_write(A_ACK, 32'h05);
        @(negedge clk);
        read_check("R2", A_STATUS, 32'h00);   // held-high source does not re-set
        drive_src('0);
    endtask

    task automatic t_ack;
        pulse_src(8'h0F);
        bus_write(A_ACK, 32'h03);
        read_check("R3", A_STATUS, 32'h0C);
        bus_write(A_ACK, 32'h0C);
        read_check("R3", A_STATUS, 32'h00);
    endtask

    task automatic t_collision;
        @(negedge clk);
        src_i     = 8'h02;
        bus_addr  = A_ACK;
        bus_wdata = 32'h02;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        read_check("R4", A_STATUS, 32'h02);
        bus_write(A_ACK, 32'h02);
        read_check("R4", A_STATUS, 32'h00);
        drive_src('0);
    endtask

    task automatic t_enable;
        bus_write(A_ENABLE, 32'hFFFF_FFA5);
        read_check("R5", A_ENABLE, 32'hA5);
        pulse_src(8'hFF);
        read_check("R5", A_ACTIVE, 32'hA5);
        check("R6", "irq enabled source", 32'(irq_o), 32'h1);
        read_check("R9", A_VECTOR, 32'h0);
        bus_write(A_ACK, 32'hFF);
        check("R6", "irq after ack", 32'(irq_o), 32'h0);
        pulse_src(8'h40);
        bus_write(A_ENABLE, 32'hBF);
        check("R6", "irq masked by enable", 32'(irq_o), 32'h0);
        bus_write(A_ACK, 32'hFF);
    endtask

    task automatic t_level;
        bus_write(A_ENABLE, 32'hFF);
        pulse_src(8'h48);
        check("R6", "irq level F", 32'(irq_o), 32'h1);
        read_check("R9", A_VECTOR, 32'h3);
        bus_write(A_LEVEL, 32'h0);
        check("R7", "irq level 0", 32'(irq_o), 32'h0);
        read_check("R9", A_VECTOR, NONE);
        bus_write(A_LEVEL, 32'h4);
        check("R8", "irq level 4", 32'(irq_o), 32'h1);
        read_check("R8", A_VECTOR, 32'h3);
        bus_write(A_LEVEL, 32'h3);
        check("R8", "irq level 3 blocks index 3", 32'(irq_o), 32'h0);
        read_check("R8", A_VECTOR, NONE);
        bus_write(A_LEVEL, 32'h7);
        bus_write(A_ACK, 32'h08);
        read_check("R8", A_VECTOR, 32'h6);
        bus_write(A_LEVEL, 32'h6);
        check("R8", "irq level 6 blocks index 6", 32'(irq_o), 32'h0);
        bus_write(A_LEVEL, 32'h1234_5679);
        read_check("R8", A_LEVEL, 32'h9);
        check("R8", "irq level 9 admits all", 32'(irq_o), 32'h1);
        bus_write(A_LEVEL, 32'hF);
        bus_write(A_ACK, 32'hFF);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        read_check("R10", 8'h10, 32'h0);
        read_check("R10", 8'h28, 32'h0);
        bus_write(A_ENABLE, 32'h3C);
        bus_write(A_LEVEL, 32'h5);
        bus_write(8'h10, 32'hFF);
        bus_write(8'h14, 32'hFF);
        bus_write(8'h1C, 32'hFF);
        bus_write(8'h20, 32'hFF);
        bus_write(A_VECTOR, 32'hFF);
        bus_write(A_STATUS, 32'hFF);
        read_check("R10", A_ENABLE, 32'h3C);
        read_check("R10", A_LEVEL, 32'h5);
        read_check("R10", A_STATUS, 32'h0);
        bus_read(A_LEVEL, v);
        check("R11", "read data value", v, 32'h5);
        @(negedge clk);
        check("R11", "rdata idle after read", bus_rdata, 32'h0);
    endtask

    initial begin : watchdog
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_edge();
        t_ack();
        t_collision();
        t_enable();
        t_level();
        t_unmapped();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule